// File: doc/BRIEF.md
# Select-Coded Arithmetic/Logic Unit

This block is a purely combinational datapath unit that takes two operands of parameterised width, a three-bit function code and a carry input, and returns a result word plus a carry output. Function codes whose top bit is clear use a single adder. The low two code bits pick the adder's second operand: zero, B, the bitwise inverse of B, or all ones. The carry input enters the adder as its low carry. One adder therefore covers transfer, increment, add, add-with-carry, subtract, subtract-with-borrow and decrement.

Function codes whose top bit is set give bitwise logic: OR, XOR, AND, and the complement of A. In this half the carry input has no effect and the carry output is held low. A surrounding datapath drives the operands and the code, and reads the result in the same cycle.

Top module: `sel_alu`

## Requirements
- R1: Code 3'b000 gives A when cin=0 and A+1 (mod 2^W) when cin=1; cout is the carry out of that sum.
- R2: Code 3'b001 gives A+B when cin=0 and A+B+1 when cin=1 (mod 2^W); cout is bit W of the full sum.
- R3: Code 3'b010 gives A-B-1 when cin=0 and A-B when cin=1 (mod 2^W); cout is bit W of A + ~B + cin.
- R4: Code 3'b011 gives A-1 when cin=0 and A when cin=1 (mod 2^W); cout is bit W of A + (2^W-1) + cin.
- R5: Code 3'b100 gives A | B, 3'b101 gives A ^ B, 3'b110 gives A & B, and 3'b111 gives ~A.
- R6: For codes 3'b100 to 3'b111, cin has no effect on the result, and cout is 0.
- R7: The width W is a parameter with a default of 8. The outputs depend only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First operand A |
| opb | input | W | Second operand B |
| fsel | input | 3 | Function code; bit 2 selects logic, bits 1:0 pick the operation |
| cin | input | 1 | Carry input for the arithmetic codes |
| res | output | W | Result word |
| cout | output | 1 | Adder carry output; 0 for the logic codes |

## Verification
The cases hardest to reach are the carry boundaries. Examples are decrement of zero, increment of all ones, and subtract with A equal to B, where the carry output flips and the result wraps. Random operands seldom land on these values. The bench therefore drives directed operand pairs (zero, all ones, equal values, the sign bit alone) through every code and carry-input combination. It then adds seeded random operands, and for the logic codes it drives the same operands with both carry values and compares the two results.

// File: rtl/sel_alu.sv
module sel_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   fsel,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W-1:0] add_b;
  logic [W:0]   sum;
  logic [W-1:0] lgc;

  always_comb begin
    case (fsel[1:0])
      2'b00:   add_b = '0;
      2'b01:   add_b = opb;
      2'b10:   add_b = ~opb;
      default: add_b = '1;
    endcase
  end

  assign sum = {1'b0, opa} + {1'b0, add_b} + {{W{1'b0}}, cin};

  always_comb begin
    case (fsel[1:0])
      2'b00:   lgc = opa | opb;
      2'b01:   lgc = opa ^ opb;
      2'b10:   lgc = opa & opb;
      default: lgc = ~opa;
    endcase
  end

  assign res  = fsel[2] ? lgc : sum[W-1:0];
  assign cout = fsel[2] ? 1'b0 : sum[W];
endmodule

module sel_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [2:0]   fsel,
  input logic         cin,
  input logic [W-1:0] res,
  input logic         cout
);
  logic [W:0] wide;
  always_comb begin
    wide = {1'b0, opa} - {1'b0, opb} - {{W{1'b0}}, ~cin};
    if (fsel[2]) begin
      a_r6_logic_no_carry: assert (cout == 1'b0);
    end
    if (fsel == 3'b000) begin
      a_r1_transfer: assert (res == opa + {{(W-1){1'b0}}, cin});
    end
    if (fsel == 3'b010) begin
      a_r3_subtract: assert (res == wide[W-1:0]);
    end
    if (fsel == 3'b011 && cin) begin
      a_r4_pass_carry: assert (res == opa && cout == 1'b1);
    end
    if (fsel == 3'b111) begin
      a_r5_complement: assert ((res ^ opa) == {W{1'b1}});
    end
  end
endmodule

bind sel_alu sel_alu_chk #(.W(W)) chk_i (.*);

// File: tb/sel_alu_tb_top.sv
`timescale 1ns/1ps
module sel_alu_tb_top;
  localparam int W = 8;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opa, opb, res;
  logic [2:0] fsel;
  logic cin, cout;
  int checks = 0, errors = 0;
  bit done = 0;

  sel_alu #(.W(W)) dut_i (.opa(opa), .opb(opb), .fsel(fsel), .cin(cin), .res(res), .cout(cout));

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [2:0] f, input logic c);
    logic [W:0] r;
    case (f)
      3'd0: r = a + c;
      3'd1: r = a + b + c;
      3'd2: r = a + (2**W - 1 - b) + c;
      3'd3: r = a + (2**W - 1) + c;
      3'd4: r = {1'b0, a | b};
      3'd5: r = {1'b0, a ^ b};
      3'd6: r = {1'b0, a & b};
      default: r = {1'b0, ~a};
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5/R6";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] f, input logic c);
    logic [W:0] exp;
    @(negedge clk);
    opa = a; opb = b; fsel = f; cin = c;
    #1;
    exp = model(a, b, f, c);
    checks++;
    if ({cout, res} !== exp) begin
      errors++;
      $display("FAIL %s f=%0d cin=%0b a=%h b=%h actual=%b_%h expected=%b_%h",
               req_of(f), f, c, a, b, cout, res, exp[W], exp[W-1:0]);
    end
  endtask

  task automatic cin_blind(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] f);
    logic [W-1:0] r0;
    logic c0;
    @(negedge clk);
    opa = a; opb = b; fsel = f; cin = 0; #1; r0 = res; c0 = cout;
    cin = 1; #1;
    checks++;
    if (res !== r0 || cout !== c0 || cout !== 1'b0) begin
      errors++;
      $display("FAIL R6 f=%0d actual=%b_%h expected=0_%h", f, cout, res, r0);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corners [5];
    void'($urandom(32'd1234));
    corners[0] = '0; corners[1] = '1; corners[2] = 8'h80; corners[3] = 8'h01; corners[4] = 8'h5a;
    opa = '0; opb = '0; fsel = '0; cin = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R7: outputs follow inputs combinationally (reset-state transfer of zero)
    apply('0, '0, 3'd0, 1'b0);
    for (int f = 0; f < 8; f++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++)
            apply(corners[i], corners[j], 3'(f), 1'(c));
    // R3 equal operands, R4 decrement of zero, R1 increment of all ones
    apply(8'h37, 8'h37, 3'd2, 1'b1);
    apply(8'h00, 8'h00, 3'd3, 1'b0);
    apply(8'hff, 8'h00, 3'd0, 1'b1);
    for (int f = 4; f < 8; f++) cin_blind(8'hc3, 8'h3c, 3'(f));
    for (int n = 0; n < 2000; n++)
      apply(W'($urandom), W'($urandom), 3'($urandom), 1'($urandom));
    for (int n = 0; n < 50; n++)
      cin_blind(W'($urandom), W'($urandom), 3'(4 + ($urandom % 4)));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule